// File: doc/BRIEF.md
# Converter Conversion Status and Result Bus Interface

This block is a synthesizable model of the digital side of a 14-bit successive-approximation converter. A start strobe opens a conversion. The conversion then runs for a fixed number of conversion-clock periods. When it finishes, a result register captures a value: either a word from a sample input port or a running conversion count that stands in for analog data. A single active-low status pin reports progress. The strobe level at the moment the conversion ends decides how that pin behaves: it gives either a one-clock end-of-conversion pulse or a busy level that lasts until the next start.

The result leaves the block on a tri-stateable parallel bus. The bus is driven only while the active-low chip-select and read inputs are both asserted. A free-run input models a strobe that is wired to the conversion clock itself. In that case the block converts back to back and pulses the status pin once for each result.

Top module: `sar_conv_status`

## Requirements
- R1: A synchronous active-high reset sets `stat_n` high and the result register to zero. After reset the bus is released (high impedance) whenever it is not selected.
- R2: A conversion is accepted on the first clock edge that samples `conv_start` high after it was sampled low. `stat_n` is high while the conversion runs. The conversion ends CONV_CLKS edges after the accepting edge, and on that edge `stat_n` goes low.
- R3: If `conv_start` is high on the edge that ends a conversion, `stat_n` stays low for exactly one clock and then returns high.
- R4: If `conv_start` is low on the edge that ends a conversion, `stat_n` stays low until the edge that accepts the next start, and that edge drives it high.
- R5: A rising edge of `conv_start` that arrives while a conversion is running is ignored. The conversion still ends at its original time, and no further conversion follows it.
- R6: The result register changes only on the edge that ends a conversion. A read during a conversion returns the previous result.
- R7: `dbus` is driven with the result only while `cs_n` and `rd_n` are both low. In every other combination of the two it is high impedance. The gating is combinational.
- R8: With `cs_n` held low, `rd_n` alone gates the result onto the bus.
- R9: While `free_run` is high, a new conversion starts on the same edge that ends the previous one. The result then updates every CONV_CLKS clocks, with a one-clock low pulse on `stat_n` each time. After `free_run` falls, the running conversion finishes and the status follows R3 or R4.
- R10: With USE_COUNTER=0, the result is `samp_in` as sampled on the ending edge. With USE_COUNTER=1, the result is the number of conversions completed since reset (1, 2, ...), modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion start strobe; its level at the end of a conversion selects the status behaviour |
| free_run | input | 1 | Models the start strobe tied to the clock: back-to-back conversions |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| samp_in | input | DW | Sample word captured as the result (sample-port variant) |
| stat_n | output | 1 | Active-low combined end-of-conversion / busy status |
| dbus | output | DW | Tri-stateable result bus |

## Verification
Count the accepting edge, where the start is first sampled high, as edge k. The ending edge is then k+CONV_CLKS: the status pin falls and the result loads on that edge. In pulse behaviour the pin rises on edge k+CONV_CLKS+1. In level behaviour it rises on the edge that accepts the next start. The bench drives all inputs just after a falling edge and samples just before the next one. After driving, it counts the falling edges it has waited. The output after N waits reflects edge k+N-1, so the bench expects the status to fall exactly at wait CONV_CLKS+1 and not one wait earlier. Bus gating is combinational, so it is checked in the same half-cycle as the change to select or read. A released bus is made visible by a pull-up.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

   // Status pin behaviour latched at the end of a conversion
   typedef enum logic {
      STAT_LEVEL = 1'b0,   // held low until the next accepted start
      STAT_PULSE = 1'b1    // low for one clock only
   } stat_mode_e;

   // Width of a counter that must reach value (n - 1)
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 2) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sar_start_det.sv
module sar_start_det (
   input  logic clk,
   input  logic rst,
   input  logic conv_start,
   input  logic free_run,
   input  logic busy,
   output logic start_acc,
   output logic end_lvl
);

   logic strobe_q;
   logic rise;

   always_ff @(posedge clk) begin
      if (rst) strobe_q <= 1'b1;   // no phantom edge straight out of reset
      else     strobe_q <= conv_start;
   end

   assign rise      = conv_start & ~strobe_q;
   // a strobe tied to the clock looks like a rising edge on every cycle
   assign start_acc = (rise | free_run) & ~busy;
   // a strobe tied to the clock is seen high when the conversion ends
   assign end_lvl   = conv_start | free_run;

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
   parameter int unsigned CONV_CLKS = 14
) (
   input  logic clk,
   input  logic rst,
   input  logic start_acc,
   input  logic free_run,
   output logic busy,
   output logic conv_end
);
   import sar_conv_pkg::*;

   localparam int unsigned CW = cnt_width(CONV_CLKS);
   localparam logic [CW-1:0] LAST = CW'(CONV_CLKS - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   assign busy     = busy_q;
   assign conv_end = busy_q && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (conv_end) begin
         cnt_q  <= '0;
         busy_q <= free_run;          // back-to-back restart
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end else if (start_acc) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end
   end

endmodule

// File: rtl/sar_stat_ctl.sv
module sar_stat_ctl (
   input  logic clk,
   input  logic rst,
   input  logic conv_end,
   input  logic end_lvl,
   input  logic start_acc,
   output logic stat_n,
   output logic pulse_mode
);
   import sar_conv_pkg::*;

   stat_mode_e mode_q;
   logic       stat_q;

   assign stat_n     = stat_q;
   assign pulse_mode = (mode_q == STAT_PULSE);

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q <= 1'b1;
         mode_q <= STAT_PULSE;
      end else if (conv_end) begin
         stat_q <= 1'b0;
         mode_q <= end_lvl ? STAT_PULSE : STAT_LEVEL;
      end else if (!stat_q && mode_q == STAT_PULSE) begin
         stat_q <= 1'b1;
      end else if (start_acc) begin
         stat_q <= 1'b1;
      end
   end

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
   parameter int unsigned DW          = 14,
   parameter bit          USE_COUNTER = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          conv_end,
   input  logic [DW-1:0] samp_in,
   output logic [DW-1:0] result
);

   logic [DW-1:0] res_q;
   assign result = res_q;

   generate
      if (USE_COUNTER) begin : g_counter
         logic [DW-1:0] seq_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               seq_q <= '0;
               res_q <= '0;
            end else if (conv_end) begin
               seq_q <= seq_q + 1'b1;
               res_q <= seq_q + 1'b1;
            end
         end
         logic unused_samp;
         assign unused_samp = ^samp_in;
      end else begin : g_sample
         always_ff @(posedge clk) begin
            if (rst)           res_q <= '0;
            else if (conv_end) res_q <= samp_in;
         end
      end
   endgenerate

endmodule

// File: rtl/sar_conv_status.sv
module sar_conv_status #(
   parameter int unsigned DW          = 14,
   parameter int unsigned CONV_CLKS   = 14,
   parameter bit          USE_COUNTER = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          conv_start,
   input  logic          free_run,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic [DW-1:0] samp_in,
   output logic          stat_n,
   output logic [DW-1:0] dbus
);

   generate
      if (DW < 1 || DW > 32) begin : g_bad_dw
         $error("sar_conv_status: DW must lie in 1..32");
      end
      if (CONV_CLKS < 2) begin : g_bad_len
         $error("sar_conv_status: CONV_CLKS must be at least 2");
      end
   endgenerate

   logic          start_acc;
   logic          end_lvl;
   logic          busy;
   logic          conv_end;
   logic          pulse_mode;
   logic [DW-1:0] result;
   logic          rd_gate;

   sar_start_det u_start (
      .clk        (clk),
      .rst        (rst),
      .conv_start (conv_start),
      .free_run   (free_run),
      .busy       (busy),
      .start_acc  (start_acc),
      .end_lvl    (end_lvl)
   );

   sar_conv_timer #(.CONV_CLKS(CONV_CLKS)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .start_acc (start_acc),
      .free_run  (free_run),
      .busy      (busy),
      .conv_end  (conv_end)
   );

   sar_stat_ctl u_stat (
      .clk        (clk),
      .rst        (rst),
      .conv_end   (conv_end),
      .end_lvl    (end_lvl),
      .start_acc  (start_acc),
      .stat_n     (stat_n),
      .pulse_mode (pulse_mode)
   );

   sar_result_reg #(.DW(DW), .USE_COUNTER(USE_COUNTER)) u_result (
      .clk      (clk),
      .rst      (rst),
      .conv_end (conv_end),
      .samp_in  (samp_in),
      .result   (result)
   );

   assign rd_gate = ~cs_n & ~rd_n;
   assign dbus    = rd_gate ? result : {DW{1'bz}};

endmodule

// File: rtl/sar_conv_status_chk.sv
module sar_conv_status_chk #(
   parameter int unsigned DW = 14
) (
   input logic          clk,
   input logic          rst,
   input logic          cs_n,
   input logic          rd_n,
   input logic          stat_n,
   input logic          busy,
   input logic          conv_end,
   input logic          start_acc,
   input logic          pulse_mode,
   input logic [DW-1:0] result,
   input logic [DW-1:0] dbus
);

   // R2
   stat_high_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !conv_end) |=> stat_n);

   // R3
   pulse_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
      (!stat_n && pulse_mode) |=> stat_n);

   // R4
   level_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!stat_n && !pulse_mode && !start_acc) |=> !stat_n);

   // R5
   conv_runs_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !conv_end) |=> busy);

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !conv_end |=> $stable(result));

   // R7
   bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !rd_n) |-> (dbus == result));

endmodule

bind sar_conv_status sar_conv_status_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cs_n       (cs_n),
   .rd_n       (rd_n),
   .stat_n     (stat_n),
   .busy       (busy),
   .conv_end   (conv_end),
   .start_acc  (start_acc),
   .pulse_mode (pulse_mode),
   .result     (result),
   .dbus       (dbus)
);

// File: tb/sar_conv_status_bench.sv
`timescale 1ns/1ps
module sar_conv_status_bench;

   localparam int unsigned DW = 14;
   localparam int unsigned N  = 14;
   localparam logic [DW-1:0] RELEASED = {DW{1'b1}};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          conv_start = 1'b0;
   logic          free_run = 1'b0;
   logic          cs_n = 1'b1;
   logic          rd_n = 1'b1;
   logic [DW-1:0] samp_in = '0;
   logic          stat_n;
   logic          stat_n_cnt;
   wire  [DW-1:0] bus_w;
   wire  [DW-1:0] bus_cnt_w;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;   // 250 MHz

   for (genvar i = 0; i < DW; i++) begin : g_pull
      pullup (bus_w[i]);
      pullup (bus_cnt_w[i]);
   end

   sar_conv_status #(.DW(DW), .CONV_CLKS(N), .USE_COUNTER(1'b0)) u_sar_conv_status (
      .clk(clk), .rst(rst), .conv_start(conv_start), .free_run(free_run),
      .cs_n(cs_n), .rd_n(rd_n), .samp_in(samp_in), .stat_n(stat_n), .dbus(bus_w)
   );

   sar_conv_status #(.DW(DW), .CONV_CLKS(N), .USE_COUNTER(1'b1)) u_sar_conv_status_cnt (
      .clk(clk), .rst(rst), .conv_start(conv_start), .free_run(free_run),
      .cs_n(cs_n), .rd_n(rd_n), .samp_in(samp_in), .stat_n(stat_n_cnt), .dbus(bus_cnt_w)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      conv_start = 1'b0; free_run = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
      @(negedge clk); rst = 1'b1;
      tick(2);
      rst = 1'b0;
      tick(1);
   endtask

   task automatic read_bus(output logic [DW-1:0] v);
      cs_n = 1'b0; rd_n = 1'b0; #0.5;
      v = bus_w;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   // R1 reset state
   task automatic t_reset();
      logic [DW-1:0] v;
      do_reset();
      check("R1 stat_n after reset", 32'(stat_n), 32'd1);
      check("R1 bus released", 32'(bus_w), 32'(RELEASED));
      read_bus(v);
      check("R1 result zero", 32'(v), 32'd0);
   endtask

   // R2, R3: strobe held high at the end -> one-clock pulse
   task automatic t_pulse_mode();
      logic [DW-1:0] v;
      do_reset();
      samp_in = 14'h1A5C;
      conv_start = 1'b1;
      tick(N);
      check("R2 stat_n high before end", 32'(stat_n), 32'd1);
      tick(1);
      check("R2 stat_n falls at end", 32'(stat_n), 32'd0);
      read_bus(v);
      check("R10 result equals sample", 32'(v), 32'h1A5C);
      tick(1);
      check("R3 stat_n back high after one clock", 32'(stat_n), 32'd1);
      tick(3);
      check("R3 stat_n stays high", 32'(stat_n), 32'd1);
      conv_start = 1'b0;
   endtask

   // R4: strobe low at the end -> level until next start
   task automatic t_level_mode();
      do_reset();
      samp_in = 14'h0333;
      conv_start = 1'b1;
      tick(1);
      conv_start = 1'b0;
      tick(N - 1);
      check("R2 stat_n high in last conversion clock", 32'(stat_n), 32'd1);
      tick(1);
      check("R4 stat_n low at end", 32'(stat_n), 32'd0);
      tick(6);
      check("R4 stat_n held low", 32'(stat_n), 32'd0);
      conv_start = 1'b1;
      tick(1);
      check("R4 stat_n high on next start", 32'(stat_n), 32'd1);
      conv_start = 1'b0;
   endtask

   // R5, R6: second start ignored; read during conversion gives old result
   task automatic t_ignore();
      logic [DW-1:0] v;
      do_reset();
      samp_in = 14'h0ABC;
      conv_start = 1'b1; tick(1); conv_start = 1'b0;
      tick(N + 2);
      samp_in = 14'h2468;
      conv_start = 1'b1; tick(1); conv_start = 1'b0;
      tick(3);
      conv_start = 1'b1; tick(1); conv_start = 1'b0;   // tick 5 of conversion
      read_bus(v);
      check("R6 read during conversion returns previous", 32'(v), 32'h0ABC);
      tick(N - 5);
      check("R5 stat_n still high before original end", 32'(stat_n), 32'd1);
      tick(1);
      check("R5 conversion ends at original time", 32'(stat_n), 32'd0);
      read_bus(v);
      check("R6 result updated at end", 32'(v), 32'h2468);
      tick(N + 2);
      check("R5 no second conversion follows", 32'(stat_n), 32'd0);
   endtask

   // R7, R8: bus gating
   task automatic t_bus();
      do_reset();
      samp_in = 14'h155A;
      conv_start = 1'b1; tick(N + 2); conv_start = 1'b0;
      cs_n = 1'b1; rd_n = 1'b0; #0.5;
      check("R7 bus released with cs_n high", 32'(bus_w), 32'(RELEASED));
      cs_n = 1'b0; rd_n = 1'b1; #0.5;
      check("R7 bus released with rd_n high", 32'(bus_w), 32'(RELEASED));
      rd_n = 1'b0; #0.5;
      check("R7 bus driven with both low", 32'(bus_w), 32'h155A);
      rd_n = 1'b1; #0.5;
      check("R8 rd_n alone releases bus", 32'(bus_w), 32'(RELEASED));
      rd_n = 1'b0; #0.5;
      check("R8 rd_n alone drives bus", 32'(bus_w), 32'h155A);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   // R9: free-running conversions
   task automatic t_free_run();
      logic [DW-1:0] v;
      do_reset();
      samp_in = 14'h0101;
      free_run = 1'b1;
      tick(N);
      check("R9 stat_n high during first conversion", 32'(stat_n), 32'd1);
      tick(1);
      check("R9 first pulse", 32'(stat_n), 32'd0);
      samp_in = 14'h0202;
      tick(1);
      check("R9 pulse lasts one clock", 32'(stat_n), 32'd1);
      tick(N - 2);
      check("R9 high before second end", 32'(stat_n), 32'd1);
      tick(1);
      check("R9 second pulse after N clocks", 32'(stat_n), 32'd0);
      read_bus(v);
      check("R9 second result", 32'(v), 32'h0202);
      free_run = 1'b0;
      tick(N);
      check("R9 third end after free_run drops", 32'(stat_n), 32'd0);
      tick(3);
      check("R9 level status after free_run drops", 32'(stat_n), 32'd0);
   endtask

   // R10: counter source numbers conversions
   task automatic t_counter();
      do_reset();
      conv_start = 1'b1; tick(N + 2); conv_start = 1'b0;
      cs_n = 1'b0; rd_n = 1'b0; #0.5;
      check("R10 counter first result", 32'(bus_cnt_w), 32'd1);
      cs_n = 1'b1; rd_n = 1'b1;
      tick(1);
      conv_start = 1'b1; tick(N + 2); conv_start = 1'b0;
      cs_n = 1'b0; rd_n = 1'b0; #0.5;
      check("R10 counter second result", 32'(bus_cnt_w), 32'd2);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_pulse_mode();
      t_level_mode();
      t_ignore();
      t_bus();
      t_free_run();
      t_counter();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule